// File: doc/BRIEF.md
# Configurable Serial Transmit Framer

This block turns bytes into asynchronous serial characters. A four-entry holding queue collects bytes pushed by the host. When the transmitter is enabled, the block takes the oldest byte and sends it on `ser_out`: a low start bit, the data bits least significant first, an optional parity bit, and a high stop period. A one-cycle `sub_tick` pulse from an outside divider paces the line, and every bit lasts OVS sub-ticks. The character shape is set by `mode_word`, which the framer copies at the start of each character. `ctl_word` carries one-cycle command strobes: enable, disable, transmit reset, break on and break off.

The controller has seven states. `ST_IDLE` holds the line high. It moves to `ST_BRK` when a break is pending, and otherwise to `ST_START` (popping the queue) when the transmitter is enabled and the queue holds data. `ST_START` drives the start bit and moves to `ST_DATA` after one bit time. `ST_DATA` shifts the data bits; after the last one it moves to `ST_PAR` if parity is on and to `ST_STOP` if not. `ST_PAR` moves to `ST_STOP` after one bit time. At the end of `ST_STOP` the controller chains directly into `ST_START` if another byte can go; otherwise it returns to `ST_IDLE`. `ST_BRK` holds the line low until the break is withdrawn, then moves to `ST_BRKREC`. That state holds the line high for one bit time and then returns to `ST_IDLE`. A transmit-reset strobe sends any state to `ST_IDLE`.

Top module: `sertx_framer`

## Requirements
- R1: The line idles high. A character is a low start bit, then the data bits least significant first, then the optional parity bit, then the high stop period. Back-to-back characters follow with no extra idle time, so the distance between start edges is 16 × (1 + data bits + parity bit) + stop ticks. Each bit lasts OVS = 16 sub-ticks.
- R2: The data length is set by mode_word[2:1]. A value of 10 gives 7 bits, 11 gives 6 bits, and 00 or 01 gives 8 bits.
- R3: Parity is set by mode_word[5:3]. 000 gives even parity (the bit makes the total count of ones even). 001 gives odd parity. 010 sends a constant 0 and 011 sends a constant 1. Any value with bit 5 set sends no parity bit.
- R4: The stop period is set by mode_word[7:6]. 00 gives 16 sub-ticks, 01 gives 24, and 10 or 11 gives 32.
- R5: ctl_word[4] enables the transmitter and ctl_word[5] disables it. If both are set, disable wins. The transmitter is disabled after reset. While disabled, no new character starts, but queued bytes are kept. Disabling during a character lets that character finish.
- R6: The queue holds 4 bytes and sends them in push order. q_full is high when 4 bytes are held and q_empty is high when none are. A push while the queue is full is dropped.
- R7: ctl_word[1] (transmit reset) empties the queue, aborts any character in progress and ends a break. One cycle later the line is high, q_empty is 1 and tx_busy is 0. The enable setting is kept.
- R8: ctl_word[7] starts a break and ctl_word[8] ends it; if both are set, ending wins. A break begins at a character boundary and holds the line low for as long as it is active, even when bytes are queued. After the break ends, the line stays high for 16 to 18 sub-ticks before the next start bit.
- R9: mode_word is copied when a character starts. Changing it during a character affects only the next character.
- R10: tx_busy is high from the start bit through the stop period, and low when idle.
- R11: After reset, ser_out is 1, q_empty is 1, q_full is 0 and tx_busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sub_tick | input | 1 | Sub-bit timing pulse from the external divider |
| push_valid | input | 1 | Writes push_data into the queue |
| push_data | input | 8 | Byte to queue |
| mode_word | input | 8 | Character format: length [2:1], parity [5:3], stop [7:6] |
| ctl_word | input | 9 | Command strobes: reset [1], enable [4], disable [5], break on [7], break off [8] |
| ser_out | output | 1 | Serial line |
| q_empty | output | 1 | Queue holds no bytes |
| q_full | output | 1 | Queue holds QDEPTH bytes |
| tx_busy | output | 1 | A character is being sent |

## Verification
The bench uses the default parameters QDEPTH = 4 and OVS = 16, and holds sub_tick high, so each sub-tick is exactly one clock. With that setting the 1.5-stop case is exactly 24 cycles, and start-to-start distances can be compared cycle-exactly against the value computed from the mode word. A depth of four lets the queue be filled with four pushes, so the dropped fifth push can be seen at the line. Every character length, parity type and stop length fits within a few hundred cycles, so the whole mode table is covered, along with disable, reset, break and mode-change tests.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int BYTE_W = 8;
    localparam int CTL_W  = 9;

    localparam int CTL_RST     = 1;
    localparam int CTL_EN      = 4;
    localparam int CTL_DIS     = 5;
    localparam int CTL_BRK_ON  = 7;
    localparam int CTL_BRK_OFF = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK,
        ST_BRKREC
    } tx_state_e;

    typedef struct packed {
        logic [3:0] nbits;
        logic       par_en;
        logic [1:0] par_kind;
        logic [1:0] stop_sel;
    } fmt_t;

    function automatic fmt_t decode_mode(input logic [7:0] m);
        fmt_t f;
        unique case (m[2:1])
            2'b10:   f.nbits = 4'd7;
            2'b11:   f.nbits = 4'd6;
            default: f.nbits = 4'd8;
        endcase
        f.par_en   = ~m[5];
        f.par_kind = m[4:3];
        f.stop_sel = m[7:6];
        return f;
    endfunction

endpackage

// File: rtl/sertx_queue.sv
module sertx_queue #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
    import sertx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] ctl_word,
    output logic             flush,
    output logic             tx_en,
    output logic             brk_on
);
    logic unused_ctl_bits;
    assign unused_ctl_bits = ^{ctl_word[0], ctl_word[3:2], ctl_word[6]};

    assign flush = ctl_word[CTL_RST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en  <= 1'b0;
            brk_on <= 1'b0;
        end else begin
            // disable strobe has priority over enable
            if (ctl_word[CTL_DIS])     tx_en <= 1'b0;
            else if (ctl_word[CTL_EN]) tx_en <= 1'b1;
            // reset and break-off both beat break-on
            if (ctl_word[CTL_RST] || ctl_word[CTL_BRK_OFF]) brk_on <= 1'b0;
            else if (ctl_word[CTL_BRK_ON])                  brk_on <= 1'b1;
        end
    end

endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              sub_tick,
    input  logic              tx_en,
    input  logic              brk_on,
    input  logic              q_empty,
    input  logic [BYTE_W-1:0] q_head,
    input  logic [7:0]        mode_word,
    output logic              pop,
    output logic              ser_out,
    output logic              busy
);
    localparam int CNTW = $clog2(2 * OVS) + 1;
    localparam logic [CNTW-1:0] LIM_ONE  = CNTW'(OVS);
    localparam logic [CNTW-1:0] LIM_1P5  = CNTW'(OVS + OVS / 2);
    localparam logic [CNTW-1:0] LIM_TWO  = CNTW'(2 * OVS);

    tx_state_e         state_q, state_d;
    logic [CNTW-1:0]   cnt_q, tick_lim;
    logic [3:0]        idx_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              par_acc_q;
    fmt_t              fmt_q;
    logic              bit_end, can_start, load_frame, par_bit;

    assign can_start = tx_en && !q_empty && !brk_on;

    always_comb begin
        tick_lim = LIM_ONE;
        if (state_q == ST_STOP) begin
            unique case (fmt_q.stop_sel)
                2'b00:   tick_lim = LIM_ONE;
                2'b01:   tick_lim = LIM_1P5;
                default: tick_lim = LIM_TWO;
            endcase
        end
    end

    assign bit_end = sub_tick && (cnt_q == tick_lim - 1'b1);

    // next-state logic
    always_comb begin
        state_d    = state_q;
        load_frame = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (brk_on) state_d = ST_BRK;
                else if (can_start) begin
                    state_d    = ST_START;
                    load_frame = 1'b1;
                end
            end
            ST_START: if (bit_end) state_d = ST_DATA;
            ST_DATA: begin
                if (bit_end && (idx_q == fmt_q.nbits - 4'd1))
                    state_d = fmt_q.par_en ? ST_PAR : ST_STOP;
            end
            ST_PAR: if (bit_end) state_d = ST_STOP;
            ST_STOP: begin
                if (bit_end) begin
                    if (can_start) begin
                        state_d    = ST_START;
                        load_frame = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_BRK:    if (!brk_on) state_d = ST_BRKREC;
            ST_BRKREC: if (bit_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state_q <= ST_IDLE;
        else if (flush) state_q <= ST_IDLE;
        else            state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            idx_q     <= '0;
            shreg_q   <= '0;
            par_acc_q <= 1'b0;
            fmt_q     <= '0;
        end else if (flush) begin
            cnt_q     <= '0;
            idx_q     <= '0;
            par_acc_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE || state_q == ST_BRK || bit_end)
                cnt_q <= '0;
            else if (sub_tick)
                cnt_q <= cnt_q + 1'b1;

            if (load_frame) begin
                shreg_q   <= q_head;
                fmt_q     <= decode_mode(mode_word);
                idx_q     <= '0;
                par_acc_q <= 1'b0;
            end else if (state_q == ST_DATA && bit_end) begin
                shreg_q   <= shreg_q >> 1;
                par_acc_q <= par_acc_q ^ shreg_q[0];
                idx_q     <= idx_q + 4'd1;
            end
        end
    end

    always_comb begin
        unique case (fmt_q.par_kind)
            2'b00:   par_bit = par_acc_q;
            2'b01:   par_bit = ~par_acc_q;
            2'b10:   par_bit = 1'b0;
            default: par_bit = 1'b1;
        endcase
    end

    // outputs
    always_comb begin
        ser_out = 1'b1;
        busy    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ser_out = 1'b1;
            ST_START:  begin ser_out = 1'b0;       busy = 1'b1; end
            ST_DATA:   begin ser_out = shreg_q[0]; busy = 1'b1; end
            ST_PAR:    begin ser_out = par_bit;    busy = 1'b1; end
            ST_STOP:   begin ser_out = 1'b1;       busy = 1'b1; end
            ST_BRK:    ser_out = 1'b0;
            ST_BRKREC: ser_out = 1'b1;
            default:   ser_out = 1'b1;
        endcase
    end

    assign pop = load_frame && !flush;

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int QDEPTH = 4,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sub_tick,
    input  logic              push_valid,
    input  logic [BYTE_W-1:0] push_data,
    input  logic [7:0]        mode_word,
    input  logic [CTL_W-1:0]  ctl_word,
    output logic              ser_out,
    output logic              q_empty,
    output logic              q_full,
    output logic              tx_busy
);
    logic              flush_w, tx_en_w, brk_on_w, pop_w;
    logic [BYTE_W-1:0] head_w;

    sertx_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_word (ctl_word),
        .flush    (flush_w),
        .tx_en    (tx_en_w),
        .brk_on   (brk_on_w)
    );

    sertx_queue #(.DW(BYTE_W), .DEPTH(QDEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_w),
        .push      (push_valid),
        .push_data (push_data),
        .pop       (pop_w),
        .head      (head_w),
        .empty     (q_empty),
        .full      (q_full)
    );

    sertx_fsm #(.OVS(OVS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_w),
        .sub_tick  (sub_tick),
        .tx_en     (tx_en_w),
        .brk_on    (brk_on_w),
        .q_empty   (q_empty),
        .q_head    (head_w),
        .mode_word (mode_word),
        .pop       (pop_w),
        .ser_out   (ser_out),
        .busy      (tx_busy)
    );

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [8:0] ctl_word,
    input logic       ser_out,
    input logic       q_empty,
    input logic       q_full,
    input logic       tx_busy,
    input logic       tx_en
);
    // R6: the queue cannot be empty and full together
    p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_empty && q_full));

    // R7: a transmit reset leaves an idle line and an empty queue
    p_flush_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_word[1] |=> (q_empty && !tx_busy && ser_out));

    // R1: a character opens with a low line
    p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !ser_out);

    // R4: a character that completes normally ends on a high stop period
    p_stop_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx_busy) && !$past(ctl_word[1])) |-> $past(ser_out));

    // R5: a disable strobe always leaves the transmitter disabled
    p_disable_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_word[5] |=> !tx_en);

endmodule

bind sertx_framer sertx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_word (ctl_word),
    .ser_out  (ser_out),
    .q_empty  (q_empty),
    .q_full   (q_full),
    .tx_busy  (tx_busy),
    .tx_en    (tx_en_w)
);

// File: tb/sim_sertx_framer.sv
module sim_sertx_framer;

    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 16;
    localparam int NVEC       = 10;

    // mode in [15:8], data in [7:0]
    localparam logic [15:0] VEC [NVEC] = '{
        16'h20_A5, 16'h00_3C, 16'h08_3C, 16'h10_81, 16'h18_7E,
        16'h24_D5, 16'h0E_2B, 16'h60_96, 16'h80_F0, 16'h46_1F
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_tick = 1'b1;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic [7:0] mode_word = 8'h20;
    logic [8:0] ctl_word = '0;
    logic       ser_out, q_empty, q_full, tx_busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    sertx_framer u0 (
        .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick),
        .push_valid(push_valid), .push_data(push_data),
        .mode_word(mode_word), .ctl_word(ctl_word),
        .ser_out(ser_out), .q_empty(q_empty), .q_full(q_full), .tx_busy(tx_busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_nbits(input logic [7:0] m);
        case (m[2:1])
            2'b10:   return 7;
            2'b11:   return 6;
            default: return 8;
        endcase
    endfunction

    function automatic int exp_stop(input logic [7:0] m);
        case (m[7:6])
            2'b00:   return OVS;
            2'b01:   return OVS + OVS / 2;
            default: return 2 * OVS;
        endcase
    endfunction

    function automatic int exp_period(input logic [7:0] m);
        return OVS * (1 + exp_nbits(m) + (m[5] ? 0 : 1)) + exp_stop(m);
    endfunction

    function automatic logic exp_par(input logic [7:0] m, input logic [7:0] d);
        logic x = 1'b0;
        for (int i = 0; i < exp_nbits(m); i++) x ^= d[i];
        case (m[4:3])
            2'b00:   return x;
            2'b01:   return ~x;
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] mask_data(input logic [7:0] m, input logic [7:0] d);
        return d & 8'((1 << exp_nbits(m)) - 1);
    endfunction

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        push_valid = 1'b1;
        push_data  = d;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic pulse_ctl(input logic [8:0] v);
        @(negedge clk);
        ctl_word = v;
        @(negedge clk);
        ctl_word = '0;
    endtask

    task automatic wait_start(output int t);
        @(negedge clk);
        while (ser_out !== 1'b0) @(negedge clk);
        t = cyc;
    endtask

    // called at the first low negedge of a start bit
    task automatic rx_bits(input logic [7:0] m, output logic [7:0] d, output logic p,
                           output logic st_ok, output logic sp_ok);
        d = '0;
        p = 1'b0;
        repeat (OVS / 2) @(negedge clk);
        st_ok = (ser_out == 1'b0);
        for (int i = 0; i < exp_nbits(m); i++) begin
            repeat (OVS) @(negedge clk);
            d[i] = ser_out;
        end
        if (!m[5]) begin
            repeat (OVS) @(negedge clk);
            p = ser_out;
        end
        repeat (OVS) @(negedge clk);
        sp_ok = (ser_out == 1'b1);
    endtask

    task automatic count_lows(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ser_out == 1'b0) lows++;
        end
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        finish_run();
    end

    initial begin
        int t0, t1, lows, gap;
        logic [7:0] d, a, b;
        logic p, so, po;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(ser_out == 1'b1, "R11 line", ser_out, 1);
        chk(q_empty == 1'b1, "R11 empty", q_empty, 1);
        chk(q_full == 1'b0, "R11 full", q_full, 0);
        chk(tx_busy == 1'b0, "R11 busy", tx_busy, 0);

        // R5 disabled after reset: queued byte is held, nothing sent
        push(8'h55);
        count_lows(80, lows);
        chk(lows == 0, "R5 disabled at reset", lows, 0);
        chk(q_empty == 1'b0, "R5 byte kept", q_empty, 0);
        pulse_ctl(9'h002);
        chk(q_empty == 1'b1, "R7 flush empties", q_empty, 1);

        // table walk: R1 R2 R3 R4 R10
        for (int k = 0; k < NVEC; k++) begin
            logic [7:0] m;
            m = VEC[k][15:8];
            a = VEC[k][7:0];
            b = ~a;
            pulse_ctl(9'h020);
            push(a);
            push(b);
            mode_word = m;
            pulse_ctl(9'h010);
            wait_start(t0);
            chk(tx_busy == 1'b1, "R10 busy in frame", tx_busy, 1);
            rx_bits(m, d, p, so, po);
            chk(so, "R1 start low", so, 1);
            chk(d == mask_data(m, a), "R1/R2 data", d, mask_data(m, a));
            if (!m[5]) chk(p == exp_par(m, a), "R3 parity", p, exp_par(m, a));
            chk(po, "R1 stop high", po, 1);
            wait_start(t1);
            chk((t1 - t0) == exp_period(m), "R4 period", t1 - t0, exp_period(m));
            rx_bits(m, d, p, so, po);
            chk(d == mask_data(m, b), "R2 second data", d, mask_data(m, b));
            if (!m[5]) chk(p == exp_par(m, b), "R3 second parity", p, exp_par(m, b));
            while (tx_busy) @(negedge clk);
            chk(q_empty == 1'b1, "R6 drained", q_empty, 1);
            chk(ser_out == 1'b1, "R10 idle high", ser_out, 1);
        end

        // R6 full queue, dropped push, order
        mode_word = 8'h20;
        pulse_ctl(9'h020);
        push(8'h11); push(8'h22); push(8'h33); push(8'h44);
        chk(q_full == 1'b1, "R6 full", q_full, 1);
        push(8'h99);
        chk(q_full == 1'b1, "R6 still full", q_full, 1);
        pulse_ctl(9'h010);
        for (int i = 0; i < 4; i++) begin
            wait_start(t0);
            rx_bits(8'h20, d, p, so, po);
            chk(d == 8'(8'h11 * (i + 1)), "R6 order", d, 8'h11 * (i + 1));
        end
        count_lows(250, lows);
        chk(lows == 0, "R6 dropped push not sent", lows, 0);
        chk(q_empty == 1'b1, "R6 empty after drain", q_empty, 1);

        // R5 disable mid-frame finishes frame, holds next
        pulse_ctl(9'h020);
        push(8'hC3); push(8'h3A);
        pulse_ctl(9'h010);
        wait_start(t0);
        fork
            rx_bits(8'h20, d, p, so, po);
            begin repeat (40) @(negedge clk); pulse_ctl(9'h020); end
        join
        chk(d == 8'hC3 && po, "R5 frame completes after disable", d, 8'hC3);
        count_lows(250, lows);
        chk(lows == 0, "R5 no frame while disabled", lows, 0);
        chk(q_empty == 1'b0, "R5 byte retained", q_empty, 0);
        // R5 enable and disable together: disable wins
        pulse_ctl(9'h030);
        count_lows(250, lows);
        chk(lows == 0, "R5 disable wins", lows, 0);
        pulse_ctl(9'h010);
        wait_start(t0);
        rx_bits(8'h20, d, p, so, po);
        chk(d == 8'h3A, "R5 held byte sent", d, 8'h3A);

        // R7 transmit reset mid-frame
        pulse_ctl(9'h020);
        push(8'h0F); push(8'hF0);
        pulse_ctl(9'h010);
        wait_start(t0);
        repeat (30) @(negedge clk);
        pulse_ctl(9'h002);
        chk(ser_out == 1'b1, "R7 line high", ser_out, 1);
        chk(tx_busy == 1'b0, "R7 not busy", tx_busy, 0);
        chk(q_empty == 1'b1, "R7 queue flushed", q_empty, 1);
        count_lows(300, lows);
        chk(lows == 0, "R7 nothing resent", lows, 0);

        // R8 break
        pulse_ctl(9'h080);
        @(negedge clk);
        chk(ser_out == 1'b0, "R8 break low", ser_out, 0);
        push(8'h6B);
        count_lows(120, lows);
        chk(lows == 120, "R8 held low with data queued", lows, 120);
        chk(q_empty == 1'b0, "R8 byte waits", q_empty, 0);
        pulse_ctl(9'h100);
        gap = 0;
        @(negedge clk);
        while (ser_out == 1'b1 && gap < 100) begin
            gap++;
            @(negedge clk);
        end
        chk(gap >= OVS && gap <= OVS + 2, "R8 recovery gap", gap, OVS + 1);
        rx_bits(8'h20, d, p, so, po);
        chk(d == 8'h6B, "R8 frame after break", d, 8'h6B);

        // R9 mode change mid-frame
        pulse_ctl(9'h020);
        push(8'h5A); push(8'h5A);
        mode_word = 8'h20;
        pulse_ctl(9'h010);
        wait_start(t0);
        mode_word = 8'h24;
        rx_bits(8'h20, d, p, so, po);
        chk(d == 8'h5A, "R9 current frame keeps mode", d, 8'h5A);
        wait_start(t1);
        chk((t1 - t0) == exp_period(8'h20), "R9 old period", t1 - t0, exp_period(8'h20));
        rx_bits(8'h24, d, p, so, po);
        chk(d == 8'h5A && po, "R9 next frame 7 bits", d, 8'h5A);
        while (tx_busy) @(negedge clk);
        count_lows(40, lows);
        chk(lows == 0, "R9 idle after", lows, 0);

        finish_run();
    end

endmodule